// File: doc/BRIEF.md
# UART Modem Handshake Unit

This block is the modem-handshake slice of one serial channel in a 16550-class UART. Software writes a modem control register over a simple parallel register bus. From that register the block drives the active-low terminal-ready and request-to-send lines, an active-low user output, and the output enable of the channel interrupt pin. It also samples the four active-low modem inputs: clear-to-send, data-set-ready, ring and carrier. Each input passes through a synchronizer. The synchronized levels form a modem status register that holds sticky change flags.

Any set change flag raises a modem-status interrupt request when the enable input from the channel's interrupt-enable logic is high. Reading the status register clears the change flags. A change that lands in the same cycle as that read still survives.

A loopback mode wires the control outputs back into the status inputs and wires the transmit serial stream straight to the receive side. Self-test software can then exercise the channel with no external connection. The serializer, baud generator, FIFOs and interrupt priority logic sit outside this block.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, dtr_n, rts_n and op_n are 1, irq_oe is 0, irq_pin is 0, and the status register change flags (bits 3:0) read 0.
- R2: A control write (address 4) with bit 4 clear makes dtr_n equal the inverse of data bit 0 and rts_n equal the inverse of data bit 1, starting in the cycle after the write.
- R3: Control bit 3 set makes irq_oe 1 and, outside loopback, op_n 0. Control bit 3 clear makes irq_oe 0 and op_n 1.
- R4: Status register (address 6) bits 4, 5, 6 and 7 read the inverted synchronized levels of cts_n, dsr_n, ri_n and cd_n, in that order. Each level is valid SYNC_STAGES cycles after the pin changes.
- R5: Status bits 0, 1 and 3 are sticky flags. Each sets on any change of the synchronized clear-to-send, data-set-ready or carrier level, respectively.
- R6: Status bit 2 sets only when ri_n goes from 0 to 1. A 1-to-0 transition of ri_n leaves it unchanged.
- R7: A read of the status register returns the current value in the same cycle and clears bits 3:0 at that clock edge. A change detected at that same edge is still recorded.
- R8: irq_pin is 1 exactly when msi_en is 1 and at least one change flag is set.
- R9: Control bit 4 selects loopback. In loopback, terminal-ready feeds data-set-ready, request-to-send feeds clear-to-send, control bit 2 feeds ring, and control bit 3 feeds carrier. The external modem inputs are ignored, and dtr_n, rts_n and op_n are held at 1.
- R10: In loopback, rx_ser follows tx_ser and tx_pin is held at 1. Outside loopback, tx_pin follows tx_ser and rx_ser follows rx_pin.
- R11: The control register reads back at address 4 with bits 4:0 as written. Bits 7:5 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of reg_rd |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring, active low |
| cd_n | input | 1 | Carrier, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| op_n | output | 1 | User output, active low |
| irq_pin | output | 1 | Modem-status interrupt request value |
| irq_oe | output | 1 | Drive enable for the interrupt pin (0 means high-impedance) |
| tx_ser | input | 1 | Serial stream from the transmitter |
| tx_pin | output | 1 | Serial line to the outside |
| rx_pin | input | 1 | Serial line from the outside |
| rx_ser | output | 1 | Serial stream to the receiver |

## Verification
The assertions check several relations on every cycle. A control write reaches the terminal-ready line one cycle later. The external lines stay inactive, and the transmit line stays marking, throughout loopback. A status read with no concurrent change leaves every change flag clear. The ring flag only ever rises after a trailing edge of the ring input. The interrupt request only rises while it is enabled.

Three behaviours need the bench's scenarios. The first is the exact synchronizer latency from pin to status bit. The second is that a carrier change that arrives at the very edge of a clearing read is preserved. The third is that the status register is fully remapped on entering and leaving loopback, including the trailing-ring flag produced when loopback is left.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;

    // Status line indices, in the order used for both level and change fields
    localparam int LN_CTS  = 0;
    localparam int LN_DSR  = 1;
    localparam int LN_RI   = 2;
    localparam int LN_CD   = 3;
    localparam int N_LINES = 4;

    localparam int CTRL_BITS = 5;

    typedef struct packed {
        logic loop;   // bit 4
        logic aux2;   // bit 3: user output / interrupt drive enable
        logic aux1;   // bit 2: internal only, feeds ring in loopback
        logic rts;    // bit 1
        logic dtr;    // bit 0
    } ctrl_t;

    typedef struct packed {
        logic [N_LINES-1:0] lvl;  // bits 7:4
        logic [N_LINES-1:0] chg;  // bits 3:0
    } stat_t;

endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import uart_mdm_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int CTRL_ADR = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CTRL_BITS-1:0] wdata,
    output ctrl_t                ctrl,
    output logic                 dtr_n,
    output logic                 rts_n,
    output logic                 op_n,
    output logic                 irq_oe
);

    typedef struct packed {
        ctrl_t ctrl;
    } st_t;

    st_t st_d, st_q;
    logic hit;

    always_comb begin
        hit  = wr && (addr == ADDR_W'(CTRL_ADR));
        st_d = st_q;
        if (hit) begin
            st_d.ctrl = ctrl_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl   = st_q.ctrl;
    assign dtr_n  = st_q.ctrl.loop ? 1'b1 : ~st_q.ctrl.dtr;
    assign rts_n  = st_q.ctrl.loop ? 1'b1 : ~st_q.ctrl.rts;
    assign op_n   = st_q.ctrl.loop ? 1'b1 : ~st_q.ctrl.aux2;
    assign irq_oe = st_q.ctrl.aux2;

    // R2
    dtr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_W'(CTRL_ADR) && !wdata[4]) |=> (dtr_n == !$past(wdata[0])));

    // R9
    loop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.loop |-> (dtr_n && rts_n && op_n));

    // R3
    op_oe_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.loop |-> (irq_oe != op_n));

endmodule

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import uart_mdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lvl,    // synchronized, active-high
    input  logic               clr,
    output stat_t              stat
);

    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] chg;
    } st_t;

    st_t st_d, st_q;
    logic [N_LINES-1:0] evt;

    always_comb begin
        evt          = lvl ^ st_q.prev;
        // ring flag only on trailing edge of the active level (pin low->high)
        evt[LN_RI]   = st_q.prev[LN_RI] & ~lvl[LN_RI];
        st_d.prev    = lvl;
        st_d.chg     = (st_q.chg & {N_LINES{~clr}}) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat.lvl = lvl;
    assign stat.chg = st_q.chg;

    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && evt == '0) |=> (stat.chg == '0));

    // R6
    ri_trail_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.chg[LN_RI]) |-> ($past(st_q.prev[LN_RI]) && !$past(lvl[LN_RI])));

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_mdm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int CTRL_ADR    = 4,
    parameter int STAT_ADR    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              msi_en,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              cd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              op_n,
    output logic              irq_pin,
    output logic              irq_oe,
    input  logic              tx_ser,
    output logic              tx_pin,
    input  logic              rx_pin,
    output logic              rx_ser
);

    localparam int STAT_W = 2 * N_LINES;

    ctrl_t              ctrl;
    stat_t              stat;
    logic [N_LINES-1:0] raw_lvl, sync_lvl;
    logic               stat_rd;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_BITS];

    mdm_ctl_reg #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADR (CTRL_ADR)
    ) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata[CTRL_BITS-1:0]),
        .ctrl   (ctrl),
        .dtr_n  (dtr_n),
        .rts_n  (rts_n),
        .op_n   (op_n),
        .irq_oe (irq_oe)
    );

    // source select ahead of the synchronizer: loopback or external pins
    always_comb begin
        if (ctrl.loop) begin
            raw_lvl[LN_CTS] = ctrl.rts;
            raw_lvl[LN_DSR] = ctrl.dtr;
            raw_lvl[LN_RI]  = ctrl.aux1;
            raw_lvl[LN_CD]  = ctrl.aux2;
        end else begin
            raw_lvl[LN_CTS] = ~cts_n;
            raw_lvl[LN_DSR] = ~dsr_n;
            raw_lvl[LN_RI]  = ~ri_n;
            raw_lvl[LN_CD]  = ~cd_n;
        end
    end

    mdm_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lvl),
        .dout (sync_lvl)
    );

    assign stat_rd = reg_rd && (reg_addr == ADDR_W'(STAT_ADR));

    mdm_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lvl),
        .clr  (stat_rd),
        .stat (stat)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == ADDR_W'(STAT_ADR)) begin
                reg_rdata[STAT_W-1:0] = stat;
            end else if (reg_addr == ADDR_W'(CTRL_ADR)) begin
                reg_rdata[CTRL_BITS-1:0] = ctrl;
            end
        end
    end

    assign irq_pin = msi_en && (stat.chg != '0);
    assign tx_pin  = ctrl.loop ? 1'b1 : tx_ser;
    assign rx_ser  = ctrl.loop ? tx_ser : rx_pin;

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pin) |-> msi_en);

    // R10
    tx_mark_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.loop |-> tx_pin);

endmodule

// File: tb/uart_modem_ctl_bench.sv
`timescale 1ns/1ps
module uart_modem_ctl_bench;

    localparam logic [2:0] A_CTRL = 3'd4;
    localparam logic [2:0] A_STAT = 3'd6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       msi_en = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic       dtr_n, rts_n, op_n, irq_pin, irq_oe;
    logic       tx_ser = 1'b1, rx_pin = 1'b1;
    logic       tx_pin, rx_ser;

    always #2.5 clk = ~clk;

    uart_modem_ctl u_uart_modem_ctl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_en(msi_en),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .op_n(op_n), .irq_pin(irq_pin), .irq_oe(irq_oe),
        .tx_ser(tx_ser), .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_ser(rx_ser)
    );

    typedef struct {
        int         kind;   // 0: read data, 1: pin vector
        logic [7:0] val;
        int         req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    logic smp = 1'b0;
    logic finished = 1'b0;

    // monitor: pops an expectation for every sample strobe
    always @(negedge clk) begin
        if (smp) begin
            exp_t e;
            logic [7:0] act;
            if (q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R0 monitor: no expectation queued");
            end else begin
                e = q.pop_front();
                act = (e.kind == 0) ? reg_rdata
                                    : {1'b0, dtr_n, rts_n, op_n, irq_oe, irq_pin, tx_pin, rx_ser};
                checks++;
                if (act !== e.val) begin
                    failures++;
                    $display("FAIL R%0d kind=%0d actual=%02h expected=%02h", e.req, e.kind, act, e.val);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] exp_v, int req);
        exp_t e;
        e.kind = 0; e.val = exp_v; e.req = req;
        q.push_back(e);
        reg_addr = a; reg_rd = 1'b1; smp = 1'b1;
        tick();
        reg_rd = 1'b0; smp = 1'b0;
    endtask

    // pin vector order: {dtr_n, rts_n, op_n, irq_oe, irq_pin, tx_pin, rx_ser}
    task automatic pins(logic [6:0] exp_v, int req);
        exp_t e;
        e.kind = 1; e.val = {1'b0, exp_v}; e.req = req;
        q.push_back(e);
        smp = 1'b1;
        tick();
        smp = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R0 watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        tick();
        // R1: reset state of outputs and status
        pins(7'b1110011, 1);
        rd(A_STAT, 8'h00, 1);

        // R2: terminal-ready and request-to-send follow control bits
        wr(A_CTRL, 8'h01);
        pins(7'b0110011, 2);
        wr(A_CTRL, 8'h02);
        pins(7'b1010011, 2);

        // R3: bit 3 drives op_n low and enables interrupt drive
        wr(A_CTRL, 8'h08);
        pins(7'b1101011, 3);
        wr(A_CTRL, 8'h00);
        pins(7'b1110011, 3);

        // R11: upper bits ignored on readback
        wr(A_CTRL, 8'hE3);
        rd(A_CTRL, 8'h03, 11);
        wr(A_CTRL, 8'h00);

        // R4 R5 R7: clear-to-send goes active, then flag clears on read
        cts_n = 1'b0;
        wait_n(4);
        rd(A_STAT, 8'h11, 5);
        rd(A_STAT, 8'h10, 7);

        // R6: ring leading edge gives level only; trailing edge sets flag
        ri_n = 1'b0;
        wait_n(4);
        rd(A_STAT, 8'h50, 6);
        ri_n = 1'b1;
        wait_n(4);
        rd(A_STAT, 8'h14, 6);
        rd(A_STAT, 8'h10, 4);

        // R8: interrupt request from data-set-ready change
        wr(A_CTRL, 8'h08);
        msi_en = 1'b1;
        dsr_n = 1'b0;
        wait_n(4);
        pins(7'b1101111, 8);
        rd(A_STAT, 8'h32, 5);
        pins(7'b1101011, 8);

        // R7: carrier change landing at the edge of a clearing read
        dsr_n = 1'b1;
        wait_n(4);
        cd_n = 1'b0;
        tick();
        tick();
        rd(A_STAT, 8'h92, 7);
        rd(A_STAT, 8'h98, 7);
        rd(A_STAT, 8'h90, 7);

        // back to idle inputs
        cts_n = 1'b1;
        cd_n = 1'b1;
        wait_n(4);
        rd(A_STAT, 8'h09, 5);
        msi_en = 1'b0;

        // R9: loopback remaps status and quiets external lines
        wr(A_CTRL, 8'h1F);
        wait_n(4);
        pins(7'b1111011, 9);
        rd(A_STAT, 8'hFB, 9);
        cts_n = 1'b0;
        wait_n(4);
        rd(A_STAT, 8'hF0, 9);

        // R10: serial loopback
        tx_ser = 1'b0;
        rx_pin = 1'b1;
        pins(7'b1111010, 10);

        // R6 R9: leaving loopback drops all levels, ring trailing flag set
        cts_n = 1'b1;
        rx_pin = 1'b0;
        wr(A_CTRL, 8'h00);
        wait_n(4);
        rd(A_STAT, 8'h0F, 6);
        // R10: normal serial path
        pins(7'b1110000, 10);
        tx_ser = 1'b1;
        rx_pin = 1'b1;
        pins(7'b1110011, 10);

        wait_n(2);
        summary();
    end

endmodule